// File: doc/BRIEF.md
# Protection Region Range Decoder

This block turns a bank of protection entries, each made of an 8-bit configuration byte and a 32-bit address register, into explicit inclusive byte-address bounds. The address register holds bits [33:2] of a 34-bit physical address. Every entry is decoded in parallel, and a count of the entries that are switched on is produced alongside the bounds. A permission checker downstream compares an access address against the low and high bounds of each entry, so it never has to interpret the match encodings itself.

The match mode of an entry is a 2-bit field inside the configuration byte. A top-of-range entry borrows its base from the address register of the entry below it, so the decode of one entry depends on its neighbour's register. All results are computed from the current register contents and captured in output registers one clock later. A synchronous active-high reset clears every output.

Top module: `pmp_range_decode`

## Requirements
- R1: The match mode is configuration bits [4:3], encoded 0 = off, 1 = top-of-range, 2 = naturally aligned 4-byte, 3 = naturally aligned power-of-two; configuration bits [7:5] and [2:0] do not affect any output.
- R2: An off entry (mode 0) reports low bound 0 and high bound 34'h3_FFFF_FFFF.
- R3: A top-of-range entry (mode 1) reports low bound = previous entry's address register shifted left by 2 and high bound = its own address register shifted left by 2, minus 1, modulo 2^34; entry 0 uses 0 as its previous address.
- R4: When the top-of-range low bound computed by R3 is greater than its high bound, both bounds are reported as 0.
- R5: A 4-byte entry (mode 2) reports low bound = address register shifted left by 2 and high bound = low bound + 3.
- R6: A power-of-two entry (mode 3) forms v = {address register, 2'b11} (34 bits) and reports low bound v & (v+1) and high bound v | (v+1), modulo 2^34.
- R7: The active count equals the number of entries whose mode is not 0.
- R8: Every output changes on the first rising clock edge after its inputs change; a clock edge with reset high sets all bounds and the count to 0.
- R9: The low bound of a top-of-range entry follows the previous entry's address register whatever mode the previous entry has, and updates when only that neighbouring register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | NUM_ENTRIES*8 | Configuration bytes, entry k at bits [8k+7:8k] |
| addr_i | input | NUM_ENTRIES*ADDR_W | Address registers, entry k at bits [ADDR_W*k+ADDR_W-1:ADDR_W*k] |
| rng_lo_o | output | NUM_ENTRIES*(ADDR_W+2) | Inclusive low byte bound per entry, same packing order |
| rng_hi_o | output | NUM_ENTRIES*(ADDR_W+2) | Inclusive high byte bound per entry, same packing order |
| active_cnt_o | output | $clog2(NUM_ENTRIES+1) | Number of entries not in the off mode |

## Verification
The only state is the output register stage, so a wrong internal value is visible at the bounds or the count on the very next sampling point after the inputs that caused it, with no hidden history to mask it. A wrong neighbour selection shows up only for top-of-range entries, and only when the adjacent address register differs from the entry's own, which is why chained and reversed neighbour patterns are driven. Arithmetic wrap-around faults appear only at the extremes: an all-ones power-of-two register, a zero top-of-range register and equal neighbouring registers.

// File: rtl/pmp_rng_pkg.sv
package pmp_rng_pkg;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } match_mode_e;

  localparam int CFG_W    = 8;
  localparam int MODE_LSB = 3;

  function automatic match_mode_e cfg_mode(input logic [CFG_W-1:0] cfg);
    return match_mode_e'(cfg[MODE_LSB +: 2]);
  endfunction

endpackage

// File: rtl/pmp_entry_decode.sv
module pmp_entry_decode
  import pmp_rng_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int PA_W  = ADDR_W + 2
) (
  input  logic [CFG_W-1:0]  cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] prev_addr,
  output logic [PA_W-1:0]   lo,
  output logic [PA_W-1:0]   hi,
  output logic              active
);

  match_mode_e     mode;
  logic [PA_W-1:0] tor_base;
  logic [PA_W-1:0] tor_top;
  logic [PA_W-1:0] na4_base;
  logic [PA_W-1:0] pow_v;
  logic [PA_W-1:0] pow_inc;

  always_comb begin
    mode     = cfg_mode(cfg);
    tor_base = {prev_addr, 2'b00};
    tor_top  = {addr, 2'b00} - PA_W'(1);
    na4_base = {addr, 2'b00};
    pow_v    = {addr, 2'b11};
    pow_inc  = pow_v + PA_W'(1);
  end

  always_comb begin
    active = (mode != MATCH_OFF);
    unique case (mode)
      MATCH_OFF: begin
        lo = '0;
        hi = '1;
      end
      MATCH_TOR: begin
        if (tor_base > tor_top) begin
          lo = '0;
          hi = '0;
        end else begin
          lo = tor_base;
          hi = tor_top;
        end
      end
      MATCH_NA4: begin
        lo = na4_base;
        hi = na4_base + PA_W'(3);
      end
      default: begin
        lo = pow_v & pow_inc;
        hi = pow_v | pow_inc;
      end
    endcase
  end

endmodule

// File: rtl/pmp_active_count.sv
module pmp_active_count #(
  parameter int NUM_ENTRIES = 16,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic [NUM_ENTRIES-1:0] active,
  output logic [CNT_W-1:0]       count
);

  always_comb begin
    count = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      count = count + CNT_W'(active[k]);
    end
  end

endmodule

// File: rtl/pmp_range_decode.sv
module pmp_range_decode
  import pmp_rng_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  localparam int PA_W  = ADDR_W + 2,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_ENTRIES*CFG_W-1:0]  cfg_i,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] addr_i,
  output logic [NUM_ENTRIES*PA_W-1:0]   rng_lo_o,
  output logic [NUM_ENTRIES*PA_W-1:0]   rng_hi_o,
  output logic [CNT_W-1:0]              active_cnt_o
);

  logic [NUM_ENTRIES*PA_W-1:0] lo_d;
  logic [NUM_ENTRIES*PA_W-1:0] hi_d;
  logic [NUM_ENTRIES-1:0]      act_d;
  logic [CNT_W-1:0]            cnt_d;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic [ADDR_W-1:0] prev;
    if (g == 0) begin : g_first
      assign prev = '0;
    end else begin : g_rest
      assign prev = addr_i[(g-1)*ADDR_W +: ADDR_W];
    end

    pmp_entry_decode #(
      .ADDR_W(ADDR_W)
    ) u_dec (
      .cfg      (cfg_i[g*CFG_W +: CFG_W]),
      .addr     (addr_i[g*ADDR_W +: ADDR_W]),
      .prev_addr(prev),
      .lo       (lo_d[g*PA_W +: PA_W]),
      .hi       (hi_d[g*PA_W +: PA_W]),
      .active   (act_d[g])
    );
  end

  pmp_active_count #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_cnt (
    .active(act_d),
    .count (cnt_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rng_lo_o     <= '0;
      rng_hi_o     <= '0;
      active_cnt_o <= '0;
    end else begin
      rng_lo_o     <= lo_d;
      rng_hi_o     <= hi_d;
      active_cnt_o <= cnt_d;
    end
  end

endmodule

// File: rtl/pmp_range_decode_chk.sv
module pmp_range_decode_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  localparam int PA_W  = ADDR_W + 2,
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_ENTRIES*8-1:0]      cfg_i,
  input logic [NUM_ENTRIES*ADDR_W-1:0] addr_i,
  input logic [NUM_ENTRIES*PA_W-1:0]   rng_lo_o,
  input logic [NUM_ENTRIES*PA_W-1:0]   rng_hi_o,
  input logic [CNT_W-1:0]              active_cnt_o
);

  logic q_valid;
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q   <= rst;
    q_valid <= !rst;
  end

  // R8: an edge following a reset edge sees cleared outputs
  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      assert_reset_clear_R8: assert (active_cnt_o == '0 && rng_lo_o == '0 && rng_hi_o == '0);
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> active_cnt_o <= CNT_W'(NUM_ENTRIES));

  assert_all_off_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (q_valid && $past(cfg_i & {NUM_ENTRIES{8'h18}}) == '0) |-> active_cnt_o == '0);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_chk
    logic [PA_W-1:0] lo;
    logic [PA_W-1:0] hi;
    assign lo = rng_lo_o[g*PA_W +: PA_W];
    assign hi = rng_hi_o[g*PA_W +: PA_W];

    assert_ordered_R4: assert property (@(posedge clk) disable iff (rst)
      q_valid |-> lo <= hi);

    assert_off_full_R2: assert property (@(posedge clk) disable iff (rst)
      (q_valid && $past(cfg_i[g*8+3 +: 2]) == 2'd0) |-> (lo == '0 && hi == '1));

    assert_na4_span_R5: assert property (@(posedge clk) disable iff (rst)
      (q_valid && $past(cfg_i[g*8+3 +: 2]) == 2'd2) |-> (hi == lo + PA_W'(3) && lo[1:0] == 2'b00));

    assert_napot_align_R6: assert property (@(posedge clk) disable iff (rst)
      (q_valid && $past(cfg_i[g*8+3 +: 2]) == 2'd3) |-> ((lo & (hi ^ lo)) == '0 && hi[1:0] == 2'b11));
  end

endmodule

bind pmp_range_decode pmp_range_decode_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_i       (cfg_i),
  .addr_i      (addr_i),
  .rng_lo_o    (rng_lo_o),
  .rng_hi_o    (rng_hi_o),
  .active_cnt_o(active_cnt_o)
);

// File: tb/test_pmp_range_decode.sv
module test_pmp_range_decode;

  localparam int N     = 16;
  localparam int AW    = 32;
  localparam int PW    = AW + 2;
  localparam int CW    = $clog2(N + 1);
  localparam logic [PW-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]    cfg_a  [N];
  logic [AW-1:0] addr_a [N];
  logic [N*8-1:0]  cfg_i;
  logic [N*AW-1:0] addr_i;
  logic [N*PW-1:0] rng_lo_o;
  logic [N*PW-1:0] rng_hi_o;
  logic [CW-1:0]   active_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      cfg_i[k*8 +: 8]    = cfg_a[k];
      addr_i[k*AW +: AW] = addr_a[k];
    end
  end

  pmp_range_decode #(.NUM_ENTRIES(N), .ADDR_W(AW)) i_pmp_range_decode (
    .clk(clk), .rst(rst), .cfg_i(cfg_i), .addr_i(addr_i),
    .rng_lo_o(rng_lo_o), .rng_hi_o(rng_hi_o), .active_cnt_o(active_cnt_o)
  );

  task automatic chk_ent(input string req, input int e, input logic [PW-1:0] elo, input logic [PW-1:0] ehi);
    logic [PW-1:0] alo, ahi;
    alo = rng_lo_o[e*PW +: PW];
    ahi = rng_hi_o[e*PW +: PW];
    checks++;
    if (alo !== elo || ahi !== ehi) begin
      errors++;
      $display("FAIL %s entry %0d: got lo=%h hi=%h expected lo=%h hi=%h", req, e, alo, ahi, elo, ehi);
    end
  endtask

  task automatic chk_cnt(input string req, input int exp);
    checks++;
    if (active_cnt_o !== CW'(exp)) begin
      errors++;
      $display("FAIL %s count: got %0d expected %0d", req, active_cnt_o, exp);
    end
  endtask

  // model of the bounds, taken from the requirement text
  task automatic model(input int e, output logic [PW-1:0] lo, output logic [PW-1:0] hi);
    logic [AW-1:0] pv;
    logic [PW-1:0] b, t, v;
    pv = (e == 0) ? '0 : addr_a[e-1];
    case (cfg_a[e][4:3])
      2'd0: begin lo = '0; hi = ALL1; end
      2'd1: begin
        b = {pv, 2'b00};
        t = {addr_a[e], 2'b00} - 1;
        if (b > t) begin lo = '0; hi = '0; end
        else begin lo = b; hi = t; end
      end
      2'd2: begin lo = {addr_a[e], 2'b00}; hi = lo + 3; end
      default: begin v = {addr_a[e], 2'b11}; lo = v & (v + 1); hi = v | (v + 1); end
    endcase
  endtask

  task automatic clear_all();
    for (int k = 0; k < N; k++) begin
      cfg_a[k]  = 8'h00;
      addr_a[k] = '0;
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int k = 0; k < N; k++) begin
      cfg_a[k]  = 8'h18;
      addr_a[k] = 32'h1234_5678 + k;
    end
    step();
    for (int k = 0; k < N; k++) chk_ent("R8 reset", k, '0, '0);
    chk_cnt("R8 reset", 0);
    rst = 1'b0;
  endtask

  task automatic t_off();
    clear_all();
    for (int k = 0; k < N; k++) addr_a[k] = 32'hA5A5_0000 + (k << 8);
    step();
    for (int k = 0; k < N; k++) chk_ent("R2 off", k, '0, ALL1);
    chk_cnt("R2 off", 0);
  endtask

  task automatic t_mode_bits();
    clear_all();
    cfg_a[0] = 8'hE7; addr_a[0] = 32'h0000_0040;   // mode 0 with other bits set
    cfg_a[1] = 8'hF7; addr_a[1] = 32'h0000_0040;   // mode 2 with other bits set
    cfg_a[2] = 8'h10; addr_a[2] = 32'h0000_0040;   // mode 2 plain
    step();
    chk_ent("R1 other bits off", 0, '0, ALL1);
    chk_ent("R1 other bits na4", 1, 34'h100, 34'h103);
    chk_ent("R1 plain na4", 2, 34'h100, 34'h103);
    chk_cnt("R1", 2);
  endtask

  task automatic t_na4();
    clear_all();
    cfg_a[2] = 8'h10; addr_a[2] = 32'h2000_0000;
    cfg_a[9] = 8'h10; addr_a[9] = 32'hFFFF_FFFF;
    step();
    chk_ent("R5 na4", 2, 34'h0_8000_0000, 34'h0_8000_0003);
    chk_ent("R5 na4 top", 9, 34'h3_FFFF_FFFC, 34'h3_FFFF_FFFF);
  endtask

  task automatic t_napot();
    clear_all();
    cfg_a[0] = 8'h18; addr_a[0] = 32'h0000_0FFF;
    cfg_a[3] = 8'h18; addr_a[3] = 32'h2000_01FF;
    cfg_a[4] = 8'h18; addr_a[4] = 32'hFFFF_FFFF;
    cfg_a[5] = 8'h18; addr_a[5] = 32'h0000_1000;
    step();
    chk_ent("R6 napot 32KiB", 0, 34'h0, 34'h7FFF);
    chk_ent("R6 napot 4KiB", 3, 34'h0_8000_0000, 34'h0_8000_0FFF);
    chk_ent("R6 napot all ones", 4, 34'h0, ALL1);
    chk_ent("R6 napot 8B", 5, 34'h4000, 34'h4007);
  endtask

  task automatic t_tor();
    clear_all();
    cfg_a[0] = 8'h08; addr_a[0] = 32'h0000_0100;
    addr_a[4] = 32'h0000_1000;
    cfg_a[5] = 8'h08; addr_a[5] = 32'h0000_2000;
    cfg_a[8] = 8'h08; addr_a[8] = 32'h0000_0000; addr_a[7] = 32'h0;
    step();
    chk_ent("R3 tor entry0", 0, 34'h0, 34'h3FF);
    chk_ent("R3 tor mid", 5, 34'h4000, 34'h7FFF);
    chk_ent("R3 tor zero wraps", 8, 34'h0, ALL1);
    chk_cnt("R7 tor count", 3);
  endtask

  task automatic t_tor_collapse();
    clear_all();
    addr_a[6] = 32'h0000_3000; cfg_a[7] = 8'h08; addr_a[7] = 32'h0000_1000;
    addr_a[10] = 32'h0000_0010; cfg_a[11] = 8'h08; addr_a[11] = 32'h0000_0010;
    addr_a[12] = 32'h0000_0010; cfg_a[13] = 8'h08; addr_a[13] = 32'h0000_0011;
    step();
    chk_ent("R4 reversed", 7, '0, '0);
    chk_ent("R4 equal", 11, '0, '0);
    chk_ent("R4 one word", 13, 34'h40, 34'h43);
  endtask

  task automatic t_tor_chain();
    clear_all();
    cfg_a[3] = 8'h18; addr_a[3] = 32'h0000_00FF;   // neighbour in napot mode
    cfg_a[4] = 8'h08; addr_a[4] = 32'h0000_0400;
    step();
    chk_ent("R9 napot neighbour", 4, 34'h3FC, 34'hFFF);
    addr_a[3] = 32'h0000_0200;                     // only the neighbour changes
    step();
    chk_ent("R9 neighbour update", 4, 34'h800, 34'hFFF);
    cfg_a[3] = 8'h10;
    step();
    chk_ent("R9 na4 neighbour", 4, 34'h800, 34'hFFF);
  endtask

  task automatic t_count();
    clear_all();
    for (int k = 0; k < N; k++) cfg_a[k] = {3'b000, 2'(k % 4), 3'b000};
    step();
    chk_cnt("R7 mixed", N - N / 4);
    for (int k = 0; k < N; k++) cfg_a[k] = 8'h1F;
    step();
    chk_cnt("R7 all active", N);
  endtask

  task automatic t_latency();
    clear_all();
    step();
    cfg_a[0] = 8'h10; addr_a[0] = 32'h10;
    #5;
    chk_ent("R8 before edge", 0, '0, ALL1);
    chk_cnt("R8 before edge", 0);
    step();
    chk_ent("R8 after edge", 0, 34'h40, 34'h43);
    chk_cnt("R8 after edge", 1);
    rst = 1'b1;
    step();
    chk_ent("R8 mid reset", 0, '0, '0);
    chk_cnt("R8 mid reset", 0);
    rst = 1'b0;
    step();
    chk_ent("R8 after reset", 0, 34'h40, 34'h43);
  endtask

  task automatic t_sweep();
    logic [PW-1:0] elo, ehi;
    int na;
    for (int it = 0; it < 12; it++) begin
      na = 0;
      for (int k = 0; k < N; k++) begin
        cfg_a[k]  = 8'($urandom);
        addr_a[k] = (it % 2 == 0) ? 32'($urandom) : 32'($urandom % 64);
        if (cfg_a[k][4:3] != 2'd0) na++;
      end
      step();
      for (int k = 0; k < N; k++) begin
        model(k, elo, ehi);
        chk_ent("R3 R4 R5 R6 sweep", k, elo, ehi);
      end
      chk_cnt("R7 sweep", na);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_all();
    repeat (2) @(negedge clk);
    t_reset();
    t_off();
    t_mode_bits();
    t_na4();
    t_napot();
    t_tor();
    t_tor_collapse();
    t_tor_chain();
    t_count();
    t_latency();
    t_sweep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule